// File: doc/BRIEF.md
# Bus-Mapped Parallel I/O Bank with Edge Interrupts

This block is a parallel I/O port for up to 32 pad lines. It sits behind a 32-bit classic WISHBONE-style slave port. Software uses it to drive pads, enable pad drivers, read pad levels and take per-line edge interrupts. An output line can be driven from the software output register or from a separate auxiliary input vector. An input line can be sampled every bus clock, or only on a chosen edge of a slow external sampling clock.

The whole block runs on the bus clock. Each pad input passes through two synchronizer flops. The external sampling clock is also synchronized, and its edges are found by comparison with a delayed copy, so it must be at least three times slower than the bus clock. A three-state handshake machine with the states `BS_IDLE`, `BS_ACK` and `BS_ERR` answers each bus request:
- `BS_IDLE` to `BS_ACK` when a request is accepted.
- `BS_IDLE` to `BS_ERR` when a narrow access is refused in strict mode.
- `BS_ACK` to `BS_IDLE` and `BS_ERR` to `BS_IDLE` unconditionally.

Register word index (address bits 5:2): 0 sampled input (read-only), 1 output, 2 driver enable, 3 interrupt enable, 4 rising-edge select, 5 auxiliary select, 6 control, 7 interrupt status, 8 external-clock select, 9 falling-external-edge select. In the control register, bit 0 is the global interrupt enable and bit 1 is the sticky pending flag.

Top module: `pio_bank`

## Requirements
- R1: After reset, all registers are zero. `dat_o`, `ack_o`, `err_o`, `irq_o`, `pad_o` and `pad_oe_o` are all low.
- R2: A request held for one cycle moves the machine from `BS_IDLE` to `BS_ACK`. `ack_o` is high for exactly the next cycle, with read data valid in that cycle, and then the machine returns to `BS_IDLE`.
- R3: With `STRICT`=1, a request whose `sel_i` is not 4'b1111 goes to `BS_ERR`. `err_o` is then high for one cycle, `ack_o` stays low and no register changes. With `STRICT`=0, `err_o` never rises.
- R4: A write with `STRICT`=0 changes only the bytes of a register whose `sel_i` bit is set (`sel_i[k]` covers data bits 8k+7:8k).
- R5: Registers are read at the word index in address bits 5:2. Bits above `LINES` read as zero. An address with bits 7:6 or 1:0 nonzero, or with index above 9, is acknowledged, reads zero and writes nothing.
- R6: `pad_oe_o` equals the driver-enable register. For each line, `pad_o` is `aux_i` when its auxiliary-select bit is 1, and the output register bit otherwise.
- R7: With its external-clock select bit at 0, a line's input reading follows `pad_i` three bus-clock edges after the pad changes.
- R8: With its external-clock select bit at 1, a line's input reading holds its value. It loads the synchronized pad only on a rising edge of the synchronized external clock when its falling-edge bit is 0, and only on a falling edge when that bit is 1.
- R9: A line whose interrupt-enable bit is 1 sets its status bit on a rising edge of its input reading when its rising-select bit is 1, and on a falling edge when it is 0. Other edges do not set it.
- R10: The control pending flag (bit 1) sets whenever any status bit sets. `irq_o` is high exactly when the control enable (bit 0) and the pending flag are both 1.
- R11: Writing 0 to a status bit or to the pending flag clears it. Writing 1 leaves it unchanged. An edge event in the same cycle as a clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Request strobe |
| we_i | input | 1 | Write when high, read when low |
| adr_i | input | 8 | Byte address |
| sel_i | input | 4 | Byte-lane selects |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data, valid with `ack_o` |
| ack_o | output | 1 | Normal completion |
| err_o | output | 1 | Error completion |
| irq_o | output | 1 | Interrupt request |
| pad_i | input | LINES | Pad input levels |
| pad_o | output | LINES | Pad output levels |
| pad_oe_o | output | LINES | Pad driver enables |
| aux_i | input | LINES | Alternative output source |
| eclk_i | input | 1 | Slow external sampling clock |

## Verification
A write takes effect on the edge that accepts the request. `ack_o`/`err_o` and read data appear in the following cycle, so the bench checks those at the falling edge one cycle after it raises the strobe. A pad change reaches the input reading after three edges (two synchronizer stages, then the sample flop). A status bit, the pending flag and `irq_o` follow one edge later. An external-clock edge needs three edges before it moves a line. The bench therefore waits at least five cycles after each pad or external-clock change before it reads back or samples `irq_o`, and samples every output at the falling edge.

// File: rtl/pio_pkg.sv
package pio_pkg;
    typedef enum logic [1:0] {
        BS_IDLE = 2'd0,
        BS_ACK  = 2'd1,
        BS_ERR  = 2'd2
    } bus_state_t;

    localparam logic [3:0] IX_IN    = 4'd0;
    localparam logic [3:0] IX_OUT   = 4'd1;
    localparam logic [3:0] IX_OE    = 4'd2;
    localparam logic [3:0] IX_INTE  = 4'd3;
    localparam logic [3:0] IX_RISE  = 4'd4;
    localparam logic [3:0] IX_AUX   = 4'd5;
    localparam logic [3:0] IX_CTRL  = 4'd6;
    localparam logic [3:0] IX_INTS  = 4'd7;
    localparam logic [3:0] IX_ECLK  = 4'd8;
    localparam logic [3:0] IX_NEG   = 4'd9;
endpackage

// File: rtl/pio_bus_fsm.sv
module pio_bus_fsm
    import pio_pkg::*;
#(
    parameter bit STRICT = 1'b0
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       cyc_i,
    input  logic       stb_i,
    input  logic [3:0] sel_i,
    output logic       take_o,
    output logic       ack_o,
    output logic       err_o
);
    bus_state_t state_q, state_d;
    logic req, lanes_ok;

    assign req      = cyc_i & stb_i;
    assign lanes_ok = !STRICT || (sel_i == 4'hF);

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= BS_IDLE;
        else       state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_IDLE: if (req) state_d = lanes_ok ? BS_ACK : BS_ERR;
            BS_ACK:  state_d = BS_IDLE;
            BS_ERR:  state_d = BS_IDLE;
            default: state_d = BS_IDLE;
        endcase
    end

    always_comb begin
        take_o = (state_q == BS_IDLE) && req && lanes_ok;
        ack_o  = (state_q == BS_ACK);
        err_o  = (state_q == BS_ERR);
    end
endmodule

// File: rtl/pio_sampler.sv
module pio_sampler #(
    parameter int LINES = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [LINES-1:0] pad_i,
    input  logic             eclk_i,
    input  logic [LINES-1:0] eclk_sel_i,
    input  logic [LINES-1:0] neg_sel_i,
    output logic [LINES-1:0] smp_o,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);
    logic [LINES-1:0] s1_q, s2_q, prev_q, load;
    logic [2:0]       ek_q;
    logic             ek_rise, ek_fall;

    assign ek_rise =  ek_q[1] & ~ek_q[2];
    assign ek_fall = ~ek_q[1] &  ek_q[2];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign load[i] = ~eclk_sel_i[i] | (neg_sel_i[i] ? ek_fall : ek_rise);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s1_q   <= '0;
            s2_q   <= '0;
            smp_o  <= '0;
            prev_q <= '0;
            ek_q   <= '0;
        end else begin
            s1_q   <= pad_i;
            s2_q   <= s1_q;
            smp_o  <= (smp_o & ~load) | (s2_q & load);
            prev_q <= smp_o;
            ek_q   <= {ek_q[1:0], eclk_i};
        end
    end

    assign rise_o =  smp_o & ~prev_q;
    assign fall_o = ~smp_o &  prev_q;
endmodule

// File: rtl/pio_bank.sv
module pio_bank
    import pio_pkg::*;
#(
    parameter int LINES  = 16,
    parameter bit STRICT = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cyc_i,
    input  logic             stb_i,
    input  logic             we_i,
    input  logic [7:0]       adr_i,
    input  logic [3:0]       sel_i,
    input  logic [31:0]      dat_i,
    output logic [31:0]      dat_o,
    output logic             ack_o,
    output logic             err_o,
    output logic             irq_o,
    input  logic [LINES-1:0] pad_i,
    output logic [LINES-1:0] pad_o,
    output logic [LINES-1:0] pad_oe_o,
    input  logic [LINES-1:0] aux_i,
    input  logic             eclk_i
);
    localparam int LW = LINES;

    logic          take, hit, wr, unused_dat;
    logic [3:0]    idx;
    logic [31:0]   lane32, rd;
    logic [LW-1:0] lmask, dnew, smp, rise, fall, ev, clr;
    logic [LW-1:0] out_q, oe_q, inte_q, rsel_q, aux_q, ints_q, eclk_q, neg_q;
    logic          ctrl_ie_q, pend_q, pend_clr;

    function automatic logic [31:0] widen(input logic [LW-1:0] v);
        logic [31:0] w;
        w = '0;
        w[LW-1:0] = v;
        return w;
    endfunction

    pio_bus_fsm #(.STRICT(STRICT)) u_fsm (
        .clk_i(clk_i), .rst_i(rst_i), .cyc_i(cyc_i), .stb_i(stb_i),
        .sel_i(sel_i), .take_o(take), .ack_o(ack_o), .err_o(err_o)
    );

    pio_sampler #(.LINES(LW)) u_smp (
        .clk_i(clk_i), .rst_i(rst_i), .pad_i(pad_i), .eclk_i(eclk_i),
        .eclk_sel_i(eclk_q), .neg_sel_i(neg_q),
        .smp_o(smp), .rise_o(rise), .fall_o(fall)
    );

    assign idx        = adr_i[5:2];
    assign hit        = (adr_i[7:6] == 2'b00) && (adr_i[1:0] == 2'b00);
    assign wr         = take & we_i & hit;
    assign lane32     = {{8{sel_i[3]}}, {8{sel_i[2]}}, {8{sel_i[1]}}, {8{sel_i[0]}}};
    assign lmask      = lane32[LW-1:0];
    assign dnew       = dat_i[LW-1:0];
    assign unused_dat = ^dat_i;

    assign ev       = inte_q & ((rsel_q & rise) | (~rsel_q & fall));
    assign clr      = (wr && idx == IX_INTS) ? (lmask & ~dnew) : '0;
    assign pend_clr = wr && (idx == IX_CTRL) && sel_i[0] && !dat_i[1];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_q     <= '0;
            oe_q      <= '0;
            inte_q    <= '0;
            rsel_q    <= '0;
            aux_q     <= '0;
            eclk_q    <= '0;
            neg_q     <= '0;
            ctrl_ie_q <= 1'b0;
        end else if (wr) begin
            unique case (idx)
                IX_OUT:  out_q  <= (out_q  & ~lmask) | (dnew & lmask);
                IX_OE:   oe_q   <= (oe_q   & ~lmask) | (dnew & lmask);
                IX_INTE: inte_q <= (inte_q & ~lmask) | (dnew & lmask);
                IX_RISE: rsel_q <= (rsel_q & ~lmask) | (dnew & lmask);
                IX_AUX:  aux_q  <= (aux_q  & ~lmask) | (dnew & lmask);
                IX_ECLK: eclk_q <= (eclk_q & ~lmask) | (dnew & lmask);
                IX_NEG:  neg_q  <= (neg_q  & ~lmask) | (dnew & lmask);
                IX_CTRL: if (sel_i[0]) ctrl_ie_q <= dat_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ints_q <= '0;
            pend_q <= 1'b0;
        end else begin
            ints_q <= (ints_q & ~clr) | ev;
            pend_q <= (pend_q & ~pend_clr) | (|ev);
        end
    end

    always_comb begin
        rd = '0;
        if (hit) begin
            unique case (idx)
                IX_IN:   rd = widen(smp);
                IX_OUT:  rd = widen(out_q);
                IX_OE:   rd = widen(oe_q);
                IX_INTE: rd = widen(inte_q);
                IX_RISE: rd = widen(rsel_q);
                IX_AUX:  rd = widen(aux_q);
                IX_CTRL: rd = {30'd0, pend_q, ctrl_ie_q};
                IX_INTS: rd = widen(ints_q);
                IX_ECLK: rd = widen(eclk_q);
                IX_NEG:  rd = widen(neg_q);
                default: rd = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)     dat_o <= '0;
        else if (take) dat_o <= rd;
    end

    assign irq_o    = ctrl_ie_q & pend_q;
    assign pad_o    = (out_q & ~aux_q) | (aux_i & aux_q);
    assign pad_oe_o = oe_q;
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk #(
    parameter int LINES  = 16,
    parameter bit STRICT = 1'b0
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             cyc_i,
    input logic             stb_i,
    input logic             we_i,
    input logic [3:0]       sel_i,
    input logic             ack_o,
    input logic             err_o,
    input logic [LINES-1:0] ints_q,
    input logic             pend_q
);
    // R2
    ack_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ack_o |=> !ack_o);

    // R2
    ack_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ack_o) |-> $past(cyc_i && stb_i));

    // R3
    done_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(ack_o && err_o));

    // R3
    err_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(err_o) |-> (STRICT && $past(sel_i != 4'hF)));

    // R10
    pend_with_status_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pend_q) |-> (ints_q != '0));

    // R11
    pend_clear_by_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(pend_q) |-> $past(cyc_i && stb_i && we_i));
endmodule

bind pio_bank pio_bank_chk #(.LINES(LINES), .STRICT(STRICT)) u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
    .sel_i(sel_i), .ack_o(ack_o), .err_o(err_o), .ints_q(ints_q), .pend_q(pend_q)
);

// File: tb/test_pio_bank.sv
module test_pio_bank;
    localparam int L = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cyc = 1'b0, stb = 1'b0, we = 1'b0, eclk = 1'b0;
    logic [7:0]    adr = '0;
    logic [3:0]    sel = '0;
    logic [31:0]   wdat = '0;
    logic [L-1:0]  pad = '0, aux = '0;
    logic [31:0]   dat_o, dat_o2;
    logic          ack, err, irq, ack2, err2, irq2;
    logic [L-1:0]  pad_o, pad_oe, pad_o2, pad_oe2;

    int checks = 0;
    int fails  = 0;
    logic [31:0] last_rd;
    logic        last_ack, last_err, last_ack2, last_err2, late_ack;

    always #10 clk = ~clk;

    pio_bank #(.LINES(L), .STRICT(1'b0)) i_pio_bank (
        .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
        .adr_i(adr), .sel_i(sel), .dat_i(wdat), .dat_o(dat_o), .ack_o(ack),
        .err_o(err), .irq_o(irq), .pad_i(pad), .pad_o(pad_o),
        .pad_oe_o(pad_oe), .aux_i(aux), .eclk_i(eclk)
    );

    pio_bank #(.LINES(L), .STRICT(1'b1)) i_pio_bank_strict (
        .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
        .adr_i(adr), .sel_i(sel), .dat_i(wdat), .dat_o(dat_o2), .ack_o(ack2),
        .err_o(err2), .irq_o(irq2), .pad_i(pad), .pad_o(pad_o2),
        .pad_oe_o(pad_oe2), .aux_i(aux), .eclk_i(eclk)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic [3:0] s);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d; sel = s;
        @(negedge clk);
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
        last_rd = dat_o; last_ack = ack; last_err = err;
        last_ack2 = ack2; last_err2 = err2;
        @(negedge clk);
        late_ack = ack;
    endtask

    task automatic wr32(input logic [7:0] a, input logic [31:0] d);
        xfer(1'b1, a, d, 4'hF);
    endtask

    task automatic rd32(input logic [7:0] a);
        xfer(1'b0, a, 32'd0, 4'hF);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 dat_o", dat_o, 0);
        check("R1 ack/err/irq", {29'd0, ack, err, irq}, 0);
        check("R1 pad_o", pad_o, 0);
        check("R1 pad_oe_o", pad_oe, 0);
        rd32(8'h04);
        check("R1 output reg", last_rd, 0);
    endtask

    task automatic t_ack();
        rd32(8'h00);
        check("R2 ack one cycle later", {30'd0, last_ack, last_err}, 32'h2);
        check("R2 ack drops", {31'd0, late_ack}, 0);
    endtask

    task automatic t_map();
        wr32(8'h04, 32'hFFFF_FFFF);
        rd32(8'h04);
        check("R5 upper bits zero", last_rd, 32'h0000_FFFF);
        wr32(8'h44, 32'h0);
        rd32(8'h04);
        check("R5 partial-decode write ignored", last_rd, 32'h0000_FFFF);
        rd32(8'h44);
        check("R5 undecoded read zero", last_rd, 0);
        rd32(8'h28);
        check("R5 index 10 reads zero, acked", {last_rd[30:0], last_ack}, 32'h1);
        wr32(8'h08, 32'h0F0F);
        rd32(8'h08);
        check("R5 driver enable readback", last_rd, 32'h0F0F);
        wr32(8'h24, 32'h8000);
        rd32(8'h24);
        check("R5 falling-select readback", last_rd, 32'h8000);
        wr32(8'h24, 32'h0);
    endtask

    task automatic t_lanes();
        wr32(8'h04, 32'h1234);
        xfer(1'b1, 8'h04, 32'hABCD, 4'b0010);
        check("R3 non-strict acks narrow", {30'd0, last_ack, last_err}, 32'h2);
        check("R3 strict errs narrow", {30'd0, last_ack2, last_err2}, 32'h1);
        rd32(8'h04);
        check("R4 byte lane merge", last_rd, 32'hAB34);
        check("R3 strict no write", pad_o2, 16'h1234);
    endtask

    task automatic t_pads();
        check("R6 pad_o follows output reg", pad_o, 16'hAB34);
        check("R6 pad_oe_o", pad_oe, 16'h0F0F);
        aux = 16'h00F0;
        wr32(8'h14, 32'h00FF);
        check("R6 aux select", pad_o, 16'hABF0);
    endtask

    task automatic t_input();
        pad = 16'hA5C3;
        wait_cyc(4);
        rd32(8'h00);
        check("R7 input follows pads", last_rd, 32'hA5C3);
    endtask

    task automatic t_eclk();
        wr32(8'h20, 32'h0003);
        wr32(8'h24, 32'h0002);
        pad = 16'h0000;
        wait_cyc(6);
        rd32(8'h00);
        check("R8 external lines hold", last_rd, 32'h0003);
        eclk = 1'b1;
        wait_cyc(5);
        rd32(8'h00);
        check("R8 rising edge loads line 0", last_rd, 32'h0002);
        eclk = 1'b0;
        wait_cyc(5);
        rd32(8'h00);
        check("R8 falling edge loads line 1", last_rd, 32'h0000);
        wr32(8'h20, 32'h0);
        wr32(8'h24, 32'h0);
    endtask

    task automatic t_irq();
        wr32(8'h0C, 32'h0005);
        wr32(8'h10, 32'h0001);
        wr32(8'h18, 32'h0001);
        pad = 16'h0007;
        wait_cyc(6);
        check("R10 irq raised", {31'd0, irq}, 1);
        rd32(8'h1C);
        check("R9 rising events", last_rd, 32'h0001);
        rd32(8'h18);
        check("R10 pending flag", last_rd, 32'h3);
        pad = 16'h0000;
        wait_cyc(6);
        rd32(8'h1C);
        check("R9 falling event line 2", last_rd, 32'h0005);
        wr32(8'h1C, 32'hFFFF_FFFF);
        rd32(8'h1C);
        check("R11 writing ones keeps status", last_rd, 32'h0005);
        wr32(8'h1C, 32'hFFFF_FFFA);
        rd32(8'h1C);
        check("R11 writing zeros clears status", last_rd, 0);
        check("R11 pending survives status clear", {31'd0, irq}, 1);
        wr32(8'h18, 32'h0001);
        check("R11 pending cleared", {31'd0, irq}, 0);
        rd32(8'h18);
        check("R11 control readback", last_rd, 32'h1);
        wr32(8'h18, 32'h0000);
        pad = 16'h0001;
        wait_cyc(6);
        check("R10 irq masked by enable", {31'd0, irq}, 0);
        rd32(8'h18);
        check("R10 pending without enable", last_rd, 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ack();
        t_map();
        t_lanes();
        t_pads();
        t_input();
        t_eclk();
        t_irq();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule